// File: doc/BRIEF.md
# Shared-Bus Slave Port with Availability Status

This block sits on the slave side of a three-stage shared bus. In the first stage a transfer is requested. In the second stage the master presents a command, an address, a 4-bit destination and a lock flag. In the third stage data moves. The slave owns one of sixteen destination identifiers and answers only traffic aimed at that identifier. Its response comes in the data stage: a ready strobe, an error strobe, and read data taken from a small local word store.

In the first stage the slave drives only its own bit of two shared 16-bit vectors. The status vector tells masters whether the local port can take a transfer now. The request vector shows that the slave is held by a locked sequence. The slave captures the second-stage fields on the clock edge that ends that stage, so the response is timed from that capture. A beat can start every cycle, which lets back-to-back and burst beats pipeline.

Top module: `tsv_bus_slave`

## Requirements
- R1: `slv_stat` has only bit SLAVE_ID able to be set, and that bit equals the inverse of `port_busy` in the same cycle. `slv_req` never sets any bit other than SLAVE_ID.
- R2: A read (command 4'd1) with destination equal to SLAVE_ID drives `bus_ready`=1, `bus_error`=0 and the addressed word on `bus_rdata` in the cycle after the capture edge, which is two cycles after the request stage.
- R3: A write (command 4'd2) with a matching destination and `bus_ready` high stores `bus_wdata` from its data-stage cycle into the addressed word. A later read returns that word.
- R4: A beat whose destination differs from SLAVE_ID gives `bus_ready`=0, `bus_error`=0 and `bus_rdata`=0 in its data stage, and it changes no stored word.
- R5: A selected beat with any command code other than 0, 1 or 2 raises `bus_error` with `bus_ready` low in its data stage, and it leaves storage unchanged.
- R6: While `port_busy` is high in a data stage, `bus_ready` stays low, read data is 0 and a write is dropped.
- R7: A selected non-idle beat sets the engagement to its `bus_lock` value at capture. `slv_req[SLAVE_ID]` shows that engagement and holds it through unselected beats.
- R8: Command 4'd0 is idle. It produces no ready, no error and no change to the engagement.
- R9: Only the low log2(DEPTH) address bits pick the word. Higher address bits are ignored.
- R10: Reset, active low and asynchronous, clears the engagement, the pending response and every stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_busy | input | 1 | Local store cannot complete a beat this cycle |
| bus_cmd | input | 4 | Stage-two command code |
| bus_addr | input | ADDR_W | Stage-two word address |
| bus_dest | input | 4 | Stage-two destination identifier |
| bus_lock | input | 1 | Stage-two lock flag |
| bus_wdata | input | DATA_W | Write data in the data stage |
| slv_req | output | 16 | Shared slave request vector, own bit only |
| slv_stat | output | 16 | Shared slave status vector, own bit only |
| bus_rdata | output | DATA_W | Read data in the data stage |
| bus_ready | output | 1 | Beat completed in the data stage |
| bus_error | output | 1 | Selected beat carried an unsupported command |

## Verification
The bench runs beats back to back so that each response overlaps the next beat's second stage. A slave that answered one cycle early or late would therefore line up with the wrong beat.

After each rejected beat, the bench reads the targeted word back:
- After an unsupported command, a design that wrote anyway would return the corrupted word.
- After a write to another destination, the same read-back exposes a write that should have been ignored.
- After a write dropped while busy, the read-back exposes a write that went through.

The bench also checks two other cases. A locked sequence is interleaved with traffic for another slave, so an engagement flag that cleared on foreign beats would drop the request bit too early. A write to an address with high bits set is read back through an alias, which catches decoding that uses the full address.

// File: rtl/tsv_bus_slave.sv
module tsv_bus_slave #(
  parameter logic [3:0] SLAVE_ID = 4'd5,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_busy,
  input  logic [3:0]        bus_cmd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_dest,
  input  logic              bus_lock,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [15:0]       slv_req,
  output logic [15:0]       slv_stat,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_error
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [3:0] CMD_IDLE = 4'd0;
  localparam logic [3:0] CMD_RD   = 4'd1;
  localparam logic [3:0] CMD_WR   = 4'd2;
  localparam logic [15:0] OWN_BIT = 16'd1 << SLAVE_ID;

  logic              sel_q, engaged;
  logic [3:0]        cmd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire hit    = (bus_dest == SLAVE_ID) && (bus_cmd != CMD_IDLE);
  wire good_q = sel_q && (cmd_q == CMD_RD || cmd_q == CMD_WR);

  assign bus_ready = good_q && !port_busy;
  assign bus_error = sel_q && !good_q;
  assign bus_rdata = (bus_ready && cmd_q == CMD_RD) ? mem[idx_q] : '0;
  assign slv_stat  = port_busy ? 16'd0 : OWN_BIT;
  assign slv_req   = engaged ? OWN_BIT : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      cmd_q   <= CMD_IDLE;
      idx_q   <= '0;
      engaged <= 1'b0;
    end else begin
      sel_q <= hit;
      cmd_q <= bus_cmd;
      idx_q <= bus_addr[IDX_W-1:0];
      if (hit) engaged <= bus_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (bus_ready && cmd_q == CMD_WR) begin
      mem[idx_q] <= bus_wdata;
    end
  end

  // R1
  own_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((slv_stat & ~OWN_BIT) == 16'd0) && ((slv_req & ~OWN_BIT) == 16'd0)
    && (slv_stat[SLAVE_ID] == !port_busy));

  // R2
  ready_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> ($past(bus_dest) == SLAVE_ID
                   && ($past(bus_cmd) == CMD_RD || $past(bus_cmd) == CMD_WR)));

  // R5
  error_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_error |-> (!bus_ready && $past(bus_dest) == SLAVE_ID
                   && $past(bus_cmd) > CMD_WR));

  // R4
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_dest) != SLAVE_ID) |-> (!bus_ready && !bus_error && bus_rdata == '0));

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> (!bus_ready && bus_rdata == '0));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_req[SLAVE_ID]) |-> $past(bus_lock));
endmodule

// File: tb/test_tsv_bus_slave.sv
module test_tsv_bus_slave;
  localparam int N = 15;
  localparam logic [15:0] OWN = 16'h0020;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [3:0]  dest;
    logic [7:0]  addr;
    logic        lock;
    logic [31:0] wdata;
    logic        busy;
    logic        e_rdy;
    logic        e_err;
    logic [31:0] e_data;
    logic        e_req;
  } vec_t;

  localparam vec_t VEC [N] = '{
    '{4'd2, 4'd5, 8'h02, 1'b0, 32'hA1, 1'b0, 1'b1, 1'b0, 32'h0,  1'b0},
    '{4'd2, 4'd5, 8'h03, 1'b1, 32'hB2, 1'b0, 1'b1, 1'b0, 32'h0,  1'b1},
    '{4'd1, 4'd5, 8'h02, 1'b1, 32'h0,  1'b0, 1'b1, 1'b0, 32'hA1, 1'b1},
    '{4'd1, 4'd3, 8'h03, 1'b0, 32'h0,  1'b0, 1'b0, 1'b0, 32'h0,  1'b1},
    '{4'd1, 4'd5, 8'h03, 1'b0, 32'h0,  1'b0, 1'b1, 1'b0, 32'hB2, 1'b0},
    '{4'd7, 4'd5, 8'h02, 1'b0, 32'hFF, 1'b0, 1'b0, 1'b1, 32'h0,  1'b0},
    '{4'd1, 4'd5, 8'h02, 1'b0, 32'h0,  1'b0, 1'b1, 1'b0, 32'hA1, 1'b0},
    '{4'd2, 4'd3, 8'h02, 1'b0, 32'hCC, 1'b0, 1'b0, 1'b0, 32'h0,  1'b0},
    '{4'd1, 4'd5, 8'h02, 1'b0, 32'h0,  1'b0, 1'b1, 1'b0, 32'hA1, 1'b0},
    '{4'd2, 4'd5, 8'h04, 1'b0, 32'hDD, 1'b1, 1'b0, 1'b0, 32'h0,  1'b0},
    '{4'd1, 4'd5, 8'h04, 1'b0, 32'h0,  1'b0, 1'b1, 1'b0, 32'h0,  1'b0},
    '{4'd0, 4'd5, 8'h02, 1'b1, 32'h0,  1'b0, 1'b0, 1'b0, 32'h0,  1'b0},
    '{4'd1, 4'd5, 8'h03, 1'b0, 32'h0,  1'b1, 1'b0, 1'b0, 32'h0,  1'b0},
    '{4'd2, 4'd5, 8'h1F, 1'b0, 32'hEE, 1'b0, 1'b1, 1'b0, 32'h0,  1'b0},
    '{4'd1, 4'd5, 8'h0F, 1'b0, 32'h0,  1'b0, 1'b1, 1'b0, 32'hEE, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, port_busy = 1'b0, bus_lock = 1'b0;
  logic [3:0] bus_cmd = 4'd0, bus_dest = 4'd0;
  logic [7:0] bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic [15:0] slv_req, slv_stat;
  logic bus_ready, bus_error;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tsv_bus_slave i_tsv_bus_slave (
    .clk(clk), .rst_n(rst_n), .port_busy(port_busy), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_dest(bus_dest), .bus_lock(bus_lock),
    .bus_wdata(bus_wdata), .slv_req(slv_req), .slv_stat(slv_stat),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_error(bus_error));

  function automatic string tag(int i);
    case (i)
      0, 1, 13: tag = "R3";
      2, 4:     tag = "R2/R7";
      3, 7, 8:  tag = "R4";
      5, 6:     tag = "R5";
      9, 10, 12: tag = "R6/R1";
      11:       tag = "R8";
      default:  tag = "R9";
    endcase
  endfunction

  task automatic check(string req, logic [67:0] act, logic [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [67:0] outs();
    outs = {bus_ready, bus_error, bus_rdata, slv_req, slv_stat};
  endfunction

  initial begin
    #1;
    check("R10 reset outputs", outs(), {1'b0, 1'b0, 32'h0, 16'h0, OWN});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (i < N) begin
        bus_cmd = VEC[i].cmd; bus_dest = VEC[i].dest;
        bus_addr = VEC[i].addr; bus_lock = VEC[i].lock;
      end else begin
        bus_cmd = 4'd0; bus_lock = 1'b0;
      end
      if (i > 0) begin
        bus_wdata = VEC[i-1].wdata; port_busy = VEC[i-1].busy;
      end
      #1;
      if (i > 0)
        check(tag(i-1), outs(), {VEC[i-1].e_rdy, VEC[i-1].e_err, VEC[i-1].e_data,
              VEC[i-1].e_req ? OWN : 16'h0, VEC[i-1].busy ? 16'h0 : OWN});
    end
    port_busy = 1'b0;
    // R7: locked beat engages, then asynchronous reset (R10) clears it
    @(negedge clk);
    bus_cmd = 4'd1; bus_dest = 4'd5; bus_addr = 8'h02; bus_lock = 1'b1;
    @(negedge clk);
    bus_cmd = 4'd0; bus_lock = 1'b0;
    #1;
    check("R7 lock engages", outs(), {1'b1, 1'b0, 32'hA1, OWN, OWN});
    rst_n = 1'b0;
    #1;
    check("R10 reset clears engagement", outs(), {1'b0, 1'b0, 32'h0, 16'h0, OWN});
    @(negedge clk);
    rst_n = 1'b1;
    bus_cmd = 4'd1; bus_dest = 4'd5; bus_addr = 8'h02;
    @(negedge clk);
    bus_cmd = 4'd0;
    #1;
    check("R10 storage cleared", outs(), {1'b1, 1'b0, 32'h0, 16'h0, OWN});
    // R1: busy while idle drops status only
    port_busy = 1'b1;
    #1;
    check("R1 status follows busy", outs(), {1'b0, 1'b0, 32'h0, 16'h0, 16'h0});
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule